// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small data cache that sits between a byte-addressed load/store port and a memory that moves whole blocks. It holds sixteen lines, one per set, and each line carries eight data bytes. A core request reads or writes from one to eight bytes. The bytes must lie inside a single block, and they are packed little-endian: the byte at the lowest offset is the least significant byte. The core keeps a request steady until the cache pulses `req_done` for one cycle.

Stores use write-back with write-allocate. A store that hits only changes the cached line and marks it dirty. A store that misses first fetches the block, then merges the new bytes into it. Memory sees a write only when a dirty line is evicted. That write-back always finishes before the refill read starts. Each memory transfer is a request that the cache holds steady until a single-cycle acknowledge.

Top module: `dm_wb_cache`

## Requirements
- R1: A request address splits into the block offset in bits [2:0], the set index in bits [6:3], and the tag in the bits above. A memory transfer uses the block address, which is the request address shifted right by three.
- R2: After reset no line is valid or dirty. The first access to any set therefore fetches from memory and never writes anything back.
- R3: An access hits only when the indexed line is valid and its stored tag equals the address tag. A valid line with a different tag is a miss.
- R4: A read of N bytes (N from 1 to 8, with offset plus N at most 8) returns the byte at address+k in bits [8k+7:8k] of `req_rdata`. Bits from 8N upward read as zero.
- R5: A write hit updates only the addressed bytes of the cached line, causes no memory transfer, and the merged line is what later reads return.
- R6: A write miss fetches the block, merges the written bytes into it, and leaves the line dirty. When that line is later evicted, memory receives the merged block.
- R7: A miss on a valid dirty line first writes the old block back to its own block address (old tag with this index), and only then issues the refill read.
- R8: A miss on a clean or invalid line performs exactly one refill read and no write.
- R9: Each memory transfer keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` constant until `mem_ack` is seen. Exactly one acknowledge completes each transfer.
- R10: `req_done` is a single-cycle pulse, one per request. A hit completes on the second clock edge after the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request present; held until `req_done` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 11 | Byte address |
| req_size | input | 4 | Number of bytes, 1 to 8 |
| req_wdata | input | 64 | Store bytes, lowest byte at bit 0 |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 64 | Load result, zero-extended |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write-back, 0 = refill read |
| mem_addr | output | 8 | Block address |
| mem_wdata | output | 64 | Block written back |
| mem_ack | input | 1 | One-cycle transfer acknowledge |
| mem_rdata | input | 64 | Refill block, valid with `mem_ack` |

## Verification
The assertions watch the properties that must hold on every cycle: the memory request stays stable while it waits for an acknowledge, a write-back acknowledge is followed at once by a refill read, `req_done` never lasts two cycles, a hit never raises a memory request, and no line is dirty without being valid. The directed scenarios show the parts that depend on history: the little-endian lane selection and byte merge, the difference between a hit and a tag mismatch, and the choice between a clean and a dirty victim. They also show that the bytes an evicted line carries back to memory are the bytes earlier stores placed there.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WB,
    ST_FILL,
    ST_SETTLE
  } cache_state_e;
endpackage

// File: rtl/cache_data_ram.sv
module cache_data_ram #(
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 4,
  parameter int LINE_W = 64
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [LINE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [LINE_W-1:0] rdata
);
  logic [LINE_W-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int SETS  = 16,
  parameter int IDX_W = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_dirty,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_en,
  input  logic [IDX_W-1:0] dirty_idx
);
  logic [SETS-1:0] valid_q;
  logic [SETS-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [SETS];

  for (genvar g = 0; g < SETS; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
        tag_q[g]   <= '0;
      end else if (fill_en && fill_idx == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
        dirty_q[g] <= 1'b0;
        tag_q[g]   <= fill_tag;
      end else if (dirty_en && dirty_idx == IDX_W'(g)) begin
        dirty_q[g] <= 1'b1;
      end
    end

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      dirty_q[g] |-> valid_q[g]); // R6
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/cache_lane_align.sv
module cache_lane_align #(
  parameter int BLOCK_BYTES = 8,
  parameter int OFFS_W      = 3,
  parameter int SIZE_W      = 4,
  localparam int LINE_W     = BLOCK_BYTES * 8
) (
  input  logic [LINE_W-1:0] line,
  input  logic [OFFS_W-1:0] offs,
  input  logic [SIZE_W-1:0] size,
  input  logic [LINE_W-1:0] wdata,
  output logic [LINE_W-1:0] rdata,
  output logic [LINE_W-1:0] merged
);
  int o_i;
  int s_i;

  always_comb begin
    o_i    = int'(offs);
    s_i    = int'(size);
    merged = line;
    rdata  = '0;
    for (int b = 0; b < BLOCK_BYTES; b++) begin
      if (b >= o_i && b < o_i + s_i)
        merged[b*8 +: 8] = wdata[(b - o_i)*8 +: 8];
      if (b < s_i && b + o_i < BLOCK_BYTES)
        rdata[b*8 +: 8] = line[(b + o_i)*8 +: 8];
    end
  end
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W      = 11,
  parameter int SETS        = 16,
  parameter int BLOCK_BYTES = 8,
  localparam int OFFS_W     = $clog2(BLOCK_BYTES),
  localparam int IDX_W      = $clog2(SETS),
  localparam int TAG_W      = ADDR_W - OFFS_W - IDX_W,
  localparam int BLK_W      = ADDR_W - OFFS_W,
  localparam int LINE_W     = BLOCK_BYTES * 8,
  localparam int SIZE_W     = OFFS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [LINE_W-1:0] req_wdata,
  output logic              req_done,
  output logic [LINE_W-1:0] req_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BLK_W-1:0]  mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [LINE_W-1:0] mem_rdata
);
  import cache_pkg::*;

  cache_state_e state_q;

  logic [OFFS_W-1:0] a_offs;
  logic [IDX_W-1:0]  a_idx;
  logic [TAG_W-1:0]  a_tag;
  assign a_offs = req_addr[OFFS_W-1:0];
  assign a_idx  = req_addr[OFFS_W +: IDX_W];
  assign a_tag  = req_addr[ADDR_W-1 -: TAG_W];

  logic             line_valid, line_dirty;
  logic [TAG_W-1:0] line_tag;
  logic [LINE_W-1:0] line_data;
  logic [LINE_W-1:0] lane_rdata, lane_merged;
  logic hit;
  logic ram_we;
  logic [LINE_W-1:0] ram_wdata;
  logic fill_en, dirty_en;

  assign hit       = line_valid && (line_tag == a_tag);
  assign fill_en   = (state_q == ST_FILL) && mem_ack;
  assign dirty_en  = (state_q == ST_LOOKUP) && hit && req_write;
  assign ram_we    = fill_en || dirty_en;
  assign ram_wdata = fill_en ? mem_rdata : lane_merged;

  cache_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_idx(a_idx), .rd_valid(line_valid), .rd_dirty(line_dirty), .rd_tag(line_tag),
    .fill_en(fill_en), .fill_idx(a_idx), .fill_tag(a_tag),
    .dirty_en(dirty_en), .dirty_idx(a_idx)
  );

  cache_data_ram #(.DEPTH(SETS), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_data (
    .clk(clk), .we(ram_we), .waddr(a_idx), .wdata(ram_wdata),
    .raddr(a_idx), .rdata(line_data)
  );

  cache_lane_align #(.BLOCK_BYTES(BLOCK_BYTES), .OFFS_W(OFFS_W), .SIZE_W(SIZE_W)) u_lane (
    .line(line_data), .offs(a_offs), .size(req_size), .wdata(req_wdata),
    .rdata(lane_rdata), .merged(lane_merged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_done  <= 1'b0;
      req_rdata <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      req_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid && !req_done) state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            if (!req_write) req_rdata <= lane_rdata;
            req_done <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (line_valid && line_dirty) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= {line_tag, a_idx};
            mem_wdata <= line_data;
            state_q   <= ST_WB;
          end else begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= {a_tag, a_idx};
            state_q  <= ST_FILL;
          end
        end
        ST_WB: begin
          if (mem_ack) begin
            mem_we   <= 1'b0;
            mem_addr <= {a_tag, a_idx};
            state_q  <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: state_q <= ST_LOOKUP;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata))); // R9
  AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done); // R10
  AST_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LOOKUP && hit) |=> !mem_req); // R5
  AST_REQ_FITS: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> (req_size != '0 && (int'(a_offs) + int'(req_size)) <= BLOCK_BYTES)); // R4
endmodule

// File: tb/dm_wb_cache_test.sv
module dm_wb_cache_test;
  localparam int ADDR_W = 11;
  localparam int BLK_W  = 8;
  localparam int NBLK   = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk; // 250 MHz

  logic        req_valid = 0, req_write = 0;
  logic [10:0] req_addr = '0;
  logic [3:0]  req_size = 4'd1;
  logic [63:0] req_wdata = '0;
  logic        req_done;
  logic [63:0] req_rdata;
  logic        mem_req, mem_we;
  logic [7:0]  mem_addr;
  logic [63:0] mem_wdata;
  logic        mem_ack = 0;
  logic [63:0] mem_rdata = '0;

  dm_wb_cache uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .req_done(req_done), .req_rdata(req_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int checks = 0;
  int fails  = 0;

  function automatic logic [63:0] init_blk(int b);
    logic [63:0] v;
    for (int k = 0; k < 8; k++) v[k*8 +: 8] = 8'((b*8 + k) * 5 + 17) ^ 8'(b);
    return v;
  endfunction

  // memory model: fixed latency, one ack per transfer, log of all transfers
  logic [63:0] mblk [NBLK];
  logic        mwritten [NBLK];
  logic        log_we   [64];
  logic [7:0]  log_addr [64];
  logic [63:0] log_data [64];
  int log_n = 0;
  int lat   = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBLK; i++) mwritten[i] <= 1'b0;
      mem_ack <= 1'b0;
      lat <= 0;
    end else if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat == 2) begin
        lat <= 0;
        mem_ack <= 1'b1;
        mem_rdata <= mwritten[mem_addr] ? mblk[mem_addr] : init_blk(int'(mem_addr));
        if (mem_we) begin
          mblk[mem_addr] <= mem_wdata;
          mwritten[mem_addr] <= 1'b1;
        end
        if (log_n < 64) begin
          log_we[log_n]   <= mem_we;
          log_addr[log_n] <= mem_addr;
          log_data[log_n] <= mem_wdata;
        end
        log_n <= log_n + 1;
      end else begin
        lat <= lat + 1;
      end
    end
  end

  // reference image of memory contents as the core sees them
  logic [63:0] refblk [NBLK];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(logic [10:0] a, int n);
    logic [63:0] r = '0;
    for (int k = 0; k < n; k++) r[k*8 +: 8] = refblk[a[10:3]][(int'(a[2:0]) + k)*8 +: 8];
    return r;
  endfunction

  int a_cyc, a_nwr, a_nrd, a_base;
  logic [63:0] a_rd;

  task automatic access(input logic w, input logic [10:0] a, input int n, input logic [63:0] wd);
    @(negedge clk);
    a_base = log_n;
    req_valid = 1; req_write = w; req_addr = a; req_size = 4'(n); req_wdata = wd;
    a_cyc = 0;
    do begin
      @(negedge clk);
      a_cyc++;
    end while (!req_done && a_cyc < 200);
    a_rd = req_rdata;
    req_valid = 0;
    a_nwr = 0; a_nrd = 0;
    for (int i = a_base; i < log_n; i++) if (log_we[i]) a_nwr++; else a_nrd++;
    if (w) for (int k = 0; k < n; k++) refblk[a[10:3]][(int'(a[2:0]) + k)*8 +: 8] = wd[k*8 +: 8];
  endtask

  task automatic t_reset;
    check("R10 done low after reset", 64'(req_done), 64'd0);
    check("R9 no mem request after reset", 64'(mem_req), 64'd0);
  endtask

  task automatic t_cold_read;
    access(0, 11'h000, 8, '0);
    check("R2 cold miss reads once", 64'(a_nrd), 64'd1);
    check("R2 cold miss writes nothing", 64'(a_nwr), 64'd0);
    check("R1 refill block address", 64'(log_addr[a_base]), 64'h00);
    check("R4 full block read", a_rd, exp_read(11'h000, 8));
  endtask

  task automatic t_hit_sizes;
    access(0, 11'h003, 2, '0);
    check("R10 hit latency", 64'(a_cyc), 64'd2);
    check("R3 hit has no mem traffic", 64'(a_nrd + a_nwr), 64'd0);
    check("R4 two bytes at offset 3", a_rd, exp_read(11'h003, 2));
    access(0, 11'h007, 1, '0);
    check("R4 last byte zero-extended", a_rd, exp_read(11'h007, 1));
    access(0, 11'h004, 4, '0);
    check("R4 upper word", a_rd, exp_read(11'h004, 4));
  endtask

  task automatic t_index;
    access(0, 11'h00B, 1, '0);
    check("R1 index 1 refill address", 64'(log_addr[a_base]), 64'h01);
    check("R4 byte from set 1", a_rd, exp_read(11'h00B, 1));
    access(0, 11'h001, 1, '0);
    check("R1 set 0 untouched by set 1 fill", 64'(a_nrd), 64'd0);
  endtask

  task automatic t_mismatch;
    access(0, 11'h083, 1, '0);
    check("R3 tag mismatch misses", 64'(a_nrd), 64'd1);
    check("R8 clean victim not written", 64'(a_nwr), 64'd0);
    check("R1 refill address for tag 1", 64'(log_addr[a_base]), 64'h10);
  endtask

  task automatic t_write_hit;
    access(1, 11'h085, 2, 64'hBEEF);
    check("R5 write hit no mem traffic", 64'(a_nrd + a_nwr), 64'd0);
    access(0, 11'h080, 8, '0);
    check("R5 merged line read back", a_rd, exp_read(11'h080, 8));
  endtask

  task automatic t_dirty_evict;
    access(0, 11'h102, 4, '0);
    check("R7 one write-back", 64'(a_nwr), 64'd1);
    check("R9 one refill transfer", 64'(a_nrd), 64'd1);
    check("R7 write-back comes first", 64'(log_we[a_base]), 64'd1);
    check("R7 write-back address", 64'(log_addr[a_base]), 64'h10);
    check("R7 write-back data", log_data[a_base], refblk[8'h10]);
    check("R7 refill address", 64'(log_addr[a_base+1]), 64'h20);
    check("R4 read after evict", a_rd, exp_read(11'h102, 4));
    access(0, 11'h085, 2, '0);
    check("R8 clean evict no write", 64'(a_nwr), 64'd0);
    check("R7 stored bytes come back from memory", a_rd, 64'hBEEF);
  endtask

  task automatic t_write_miss;
    access(1, 11'h3F2, 4, 64'hA1B2C3D4);
    check("R6 write miss fetches", 64'(a_nrd), 64'd1);
    check("R6 write miss clean victim", 64'(a_nwr), 64'd0);
    access(0, 11'h3F0, 8, '0);
    check("R6 merged after allocate", a_rd, exp_read(11'h3F0, 8));
    check("R6 allocated line hits", 64'(a_cyc), 64'd2);
    access(0, 11'h072, 1, '0);
    check("R6 allocated line is dirty", 64'(a_nwr), 64'd1);
    check("R6 write-back address", 64'(log_addr[a_base]), 64'h7E);
    check("R6 write-back holds merged bytes", log_data[a_base], refblk[8'h7E]);
  endtask

  initial begin
    for (int i = 0; i < NBLK; i++) refblk[i] = init_blk(i);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_cold_read();
    t_hit_sizes();
    t_index();
    t_mismatch();
    t_write_hit();
    t_dirty_evict();
    t_write_miss();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule